// File: doc/BRIEF.md
# PCI Base Address Range Decoder

This block sits beside the configuration space of a PCI function. It takes the two decode-enable bits of the command register, the programmed values of up to six base address registers, the expansion ROM register, and the fixed size and type of every region. From these it works out which region, if any, claims an incoming I/O or memory access. It reports a hit flag, the index of the claiming region, and the byte offset of the access within that region. The address decode is combinational, so the bus logic can use it in the same cycle that it presents the address.

The block also publishes the base address each region currently occupies, with a valid bit per region. These outputs are registered and follow any change of the configuration inputs one clock later. A region that is switched off, badly placed or of zero size shows its valid bit low and a base of zero. The expansion ROM is reported as region index NUM_BARS, which is 6 at the default setting.

Top module: `bar_range_decoder`

## Requirements
- R1: A region whose type bit 0 is 1 is an I/O region and is decoded only while `cmd_enables[0]` is 1. Any other region is a memory region and is decoded only while `cmd_enables[1]` is 1.
- R2: The expansion ROM region is a memory region. It is decoded only when `cmd_enables[1]` is 1 and bit 0 of `rom_reg` is also 1.
- R3: The base of a region is its register value ANDed with ~(size-1). The region claims addresses from the base through base+size-1 inclusive.
- R4: An I/O region whose base is zero, or whose last address is above 0xFFFF, is unmapped.
- R5: A memory region whose base is zero, or whose last address would pass 0xFFFFFFFF, is unmapped.
- R6: A region of size 0 never claims an address and is always reported as unmapped.
- R7: Where several regions claim an address, the one with the lowest BAR index wins. The ROM (index NUM_BARS) has the lowest priority of all.
- R8: On a hit, `hit_off` equals the access address minus the base of the winning region. With no hit, `hit`, `hit_idx` and `hit_off` are all zero.
- R9: An I/O access (`acc_is_io`=1) is matched only against I/O regions. A memory access is matched only against memory regions and the ROM.
- R10: `map_valid` and `map_base` show the live state and base of each region one clock after the inputs change. Region k sits at bits [32k+31:32k] and the ROM is at index NUM_BARS. An unmapped region shows valid 0 and base 0. During reset, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_enables | input | 2 | Bit 0: I/O decode enable. Bit 1: memory decode enable |
| bar_vals | input | NUM_BARS*32 | Programmed value of each BAR |
| bar_sizes | input | NUM_BARS*32 | Size of each BAR in bytes (a power of two, or 0) |
| bar_is_io | input | NUM_BARS | Type bit 0 of each BAR (1 = I/O) |
| rom_reg | input | 32 | Expansion ROM register. Bit 0 is the ROM enable |
| rom_size | input | 32 | ROM size in bytes (a power of two, or 0) |
| acc_addr | input | 32 | Address of the incoming access |
| acc_is_io | input | 1 | 1 for an I/O access, 0 for a memory access |
| hit | output | 1 | Some region claims the access |
| hit_idx | output | $clog2(NUM_BARS+1) | Index of the claiming region |
| hit_off | output | 32 | Offset of the access within the claiming region |
| map_base | output | (NUM_BARS+1)*32 | Registered current base of each region |
| map_valid | output | NUM_BARS+1 | Registered mapped flag of each region |

## Verification
The outputs `hit`, `hit_idx` and `hit_off` settle in the same cycle as their inputs. The bench therefore changes inputs on the falling edge and samples these outputs 1 ns later, before any rising edge. `map_valid` and `map_base` come one rising edge after a change. The bench checks them twice around a configuration change: once just before the next rising edge, where they must still hold the old values, and once just after it, where they must hold the new ones.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;
  localparam int ADDR_W      = 32;
  localparam int CMD_IO_BIT  = 0;
  localparam int CMD_MEM_BIT = 1;
  localparam logic [ADDR_W:0] IO_TOP = 33'h0_0000_FFFF;

  // aligned base: register value with the size-sized low part cleared
  function automatic logic [ADDR_W-1:0] align_base(input logic [ADDR_W-1:0] val,
                                                   input logic [ADDR_W-1:0] size);
    return val & ~(size - 1'b1);
  endfunction

  // last address, one extra bit to expose a wrap past the address space
  function automatic logic [ADDR_W:0] last_addr(input logic [ADDR_W-1:0] base,
                                                input logic [ADDR_W-1:0] size);
    return {1'b0, base} + {1'b0, size} - 1'b1;
  endfunction
endpackage

// File: rtl/bar_region_eval.sv
module bar_region_eval
  import bar_dec_pkg::*;
(
  input  logic [ADDR_W-1:0] reg_val,
  input  logic [ADDR_W-1:0] reg_size,
  input  logic              is_io_region,
  input  logic              is_rom,
  input  logic              io_en,
  input  logic              mem_en,
  input  logic              rom_en,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_is_io,
  output logic              live,
  output logic              claim,
  output logic [ADDR_W-1:0] base
);
  logic [ADDR_W-1:0] base_raw;
  logic [ADDR_W:0]   last;
  logic              enabled;
  logic              placed_ok;

  always_comb begin
    base_raw  = align_base(reg_val, reg_size);
    last      = last_addr(base_raw, reg_size);
    enabled   = is_io_region ? io_en : (mem_en && (!is_rom || rom_en));
    placed_ok = (base_raw != '0) &&
                (is_io_region ? (last <= IO_TOP) : !last[ADDR_W]);
    live      = (reg_size != '0) && enabled && placed_ok;
    claim     = live && (acc_is_io == is_io_region) &&
                (acc_addr >= base_raw) && ({1'b0, acc_addr} <= last);
    base      = live ? base_raw : '0;
  end
endmodule

// File: rtl/bar_prio_select.sv
module bar_prio_select
  import bar_dec_pkg::*;
#(
  parameter int NREG = 7,
  localparam int IW  = $clog2(NREG)
)(
  input  logic [NREG-1:0]        claim_vec,
  input  logic [NREG*ADDR_W-1:0] base_vec,
  input  logic [ADDR_W-1:0]      acc_addr,
  output logic                   hit,
  output logic [IW-1:0]          hit_idx,
  output logic [ADDR_W-1:0]      hit_off
);
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    hit_off = '0;
    // walk from the highest index down so the lowest claimant is kept last
    for (int i = NREG - 1; i >= 0; i--) begin
      if (claim_vec[i]) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
        hit_off = acc_addr - base_vec[i*ADDR_W +: ADDR_W];
      end
    end
  end
endmodule

// File: rtl/bar_range_decoder.sv
module bar_range_decoder
  import bar_dec_pkg::*;
#(
  parameter int NUM_BARS = 6,
  localparam int NREG    = NUM_BARS + 1,
  localparam int IW      = $clog2(NREG),
  localparam int ROM_IDX = NUM_BARS
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 cmd_enables,
  input  logic [NUM_BARS*ADDR_W-1:0] bar_vals,
  input  logic [NUM_BARS*ADDR_W-1:0] bar_sizes,
  input  logic [NUM_BARS-1:0]        bar_is_io,
  input  logic [ADDR_W-1:0]          rom_reg,
  input  logic [ADDR_W-1:0]          rom_size,
  input  logic [ADDR_W-1:0]          acc_addr,
  input  logic                       acc_is_io,
  output logic                       hit,
  output logic [IW-1:0]              hit_idx,
  output logic [ADDR_W-1:0]          hit_off,
  output logic [NREG*ADDR_W-1:0]     map_base,
  output logic [NREG-1:0]            map_valid
);
  logic [NREG-1:0]        live_vec;
  logic [NREG-1:0]        claim_vec;
  logic [NREG*ADDR_W-1:0] base_vec;

  generate
    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
      bar_region_eval u_eval (
        .reg_val      (bar_vals[g*ADDR_W +: ADDR_W]),
        .reg_size     (bar_sizes[g*ADDR_W +: ADDR_W]),
        .is_io_region (bar_is_io[g]),
        .is_rom       (1'b0),
        .io_en        (cmd_enables[CMD_IO_BIT]),
        .mem_en       (cmd_enables[CMD_MEM_BIT]),
        .rom_en       (1'b0),
        .acc_addr     (acc_addr),
        .acc_is_io    (acc_is_io),
        .live         (live_vec[g]),
        .claim        (claim_vec[g]),
        .base         (base_vec[g*ADDR_W +: ADDR_W])
      );
    end
  endgenerate

  bar_region_eval u_rom_eval (
    .reg_val      (rom_reg),
    .reg_size     (rom_size),
    .is_io_region (1'b0),
    .is_rom       (1'b1),
    .io_en        (cmd_enables[CMD_IO_BIT]),
    .mem_en       (cmd_enables[CMD_MEM_BIT]),
    .rom_en       (rom_reg[0]),
    .acc_addr     (acc_addr),
    .acc_is_io    (acc_is_io),
    .live         (live_vec[ROM_IDX]),
    .claim        (claim_vec[ROM_IDX]),
    .base         (base_vec[ROM_IDX*ADDR_W +: ADDR_W])
  );

  bar_prio_select #(.NREG(NREG)) u_prio (
    .claim_vec (claim_vec),
    .base_vec  (base_vec),
    .acc_addr  (acc_addr),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .hit_off   (hit_off)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_base  <= '0;
      map_valid <= '0;
    end else begin
      map_base  <= base_vec;
      map_valid <= live_vec;
    end
  end

  // R7
  prio_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((claim_vec & ((NREG'(1) << hit_idx) - NREG'(1))) == '0));

  // R1
  io_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && acc_is_io) |-> cmd_enables[CMD_IO_BIT]);

  // R2
  rom_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && hit_idx == IW'(ROM_IDX)) |-> (rom_reg[0] && cmd_enables[CMD_MEM_BIT]));

  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_idx == '0 && hit_off == '0));

  // R10
  map_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (map_valid == $past(live_vec)));
endmodule

// File: tb/tb_bar_range_decoder.sv
module tb_bar_range_decoder;
  localparam int NB = 6;
  localparam int NR = NB + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        cmd_enables;
  logic [NB*32-1:0]  bar_vals, bar_sizes;
  logic [NB-1:0]     bar_is_io;
  logic [31:0]       rom_reg, rom_size, acc_addr;
  logic              acc_is_io;
  logic              hit;
  logic [2:0]        hit_idx;
  logic [31:0]       hit_off;
  logic [NR*32-1:0]  map_base;
  logic [NR-1:0]     map_valid;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bar_range_decoder #(.NUM_BARS(NB)) dut (.*);

  // {is_io, addr, exp_hit, exp_idx, exp_off}
  localparam logic [68:0] VEC [12] = '{
    {1'b0, 32'h8000_0010, 1'b1, 3'd0, 32'h0000_0010},  // R3 R7 BAR0 over BAR2
    {1'b0, 32'h8000_1004, 1'b1, 3'd2, 32'h0000_1004},  // R7 only BAR2 left
    {1'b0, 32'h8001_8000, 1'b1, 3'd6, 32'h0001_8000},  // R7 ROM alone
    {1'b0, 32'h8002_0000, 1'b0, 3'd0, 32'h0},          // R3 past ROM end
    {1'b1, 32'h0000_C0FF, 1'b1, 3'd1, 32'h0000_00FF},  // R3 R8 last I/O byte
    {1'b1, 32'h0000_C100, 1'b0, 3'd0, 32'h0},          // R3 one past I/O end
    {1'b0, 32'h0000_C010, 1'b0, 3'd0, 32'h0},          // R9 memory access to I/O range
    {1'b1, 32'h8000_0010, 1'b0, 3'd0, 32'h0},          // R9 I/O access to memory range
    {1'b1, 32'hFFFF_0010, 1'b0, 3'd0, 32'h0},          // R4 I/O above 64K
    {1'b0, 32'h0000_0010, 1'b0, 3'd0, 32'h0},          // R5 zero base
    {1'b0, 32'h9000_0000, 1'b0, 3'd0, 32'h0},          // R6 zero size
    {1'b1, 32'h0000_BFFF, 1'b0, 3'd0, 32'h0}           // R3 one below I/O base
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic io, input logic [31:0] a);
    @(negedge clk);
    acc_is_io = io;
    acc_addr  = a;
    #1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    cmd_enables = 2'b11;
    bar_is_io   = 6'b010010;
    bar_vals    = '0;
    bar_sizes   = '0;
    bar_vals[0*32 +: 32] = 32'h8000_0123; bar_sizes[0*32 +: 32] = 32'h0000_1000;
    bar_vals[1*32 +: 32] = 32'h0000_C001; bar_sizes[1*32 +: 32] = 32'h0000_0100;
    bar_vals[2*32 +: 32] = 32'h8000_0000; bar_sizes[2*32 +: 32] = 32'h0001_0000;
    bar_vals[3*32 +: 32] = 32'h9000_0000; bar_sizes[3*32 +: 32] = 32'h0;
    bar_vals[4*32 +: 32] = 32'hFFFF_0000; bar_sizes[4*32 +: 32] = 32'h0000_0100;
    bar_vals[5*32 +: 32] = 32'h0000_0000; bar_sizes[5*32 +: 32] = 32'h0000_1000;
    rom_reg   = 32'h8000_0001;
    rom_size  = 32'h0002_0000;
    acc_addr  = '0;
    acc_is_io = 1'b0;

    // R10 reset state
    repeat (2) @(posedge clk);
    #1;
    chk("R10 reset valid", 32'(map_valid), 32'h0);
    chk("R10 reset base", map_base[0*32 +: 32], 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    // R10 R4 R5 R6 mapped set and bases
    chk("R10 R4 R5 R6 valid", 32'(map_valid), 32'h47);
    chk("R10 R3 BAR0 base", map_base[0*32 +: 32], 32'h8000_0000);
    chk("R10 R3 BAR1 base", map_base[1*32 +: 32], 32'h0000_C000);
    chk("R10 R4 BAR4 base", map_base[4*32 +: 32], 32'h0);
    chk("R10 R3 ROM base", map_base[6*32 +: 32], 32'h8000_0000);

    for (int i = 0; i < 12; i++) begin
      access(VEC[i][68], VEC[i][67:36]);
      chk($sformatf("vec%0d hit", i), 32'(hit), 32'(VEC[i][35]));
      chk($sformatf("vec%0d idx", i), 32'(hit_idx), 32'(VEC[i][34:32]));
      chk($sformatf("vec%0d off", i), hit_off, VEC[i][31:0]);
    end

    // R1 only the I/O enable set
    @(negedge clk); cmd_enables = 2'b01;
    access(1'b0, 32'h8000_0010);
    chk("R1 mem off", 32'(hit), 32'h0);
    access(1'b1, 32'h0000_C010);
    chk("R1 io on", 32'(hit), 32'h1);
    // R1 only the memory enable set
    @(negedge clk); cmd_enables = 2'b10;
    access(1'b1, 32'h0000_C010);
    chk("R1 io off", 32'(hit), 32'h0);

    // R2 ROM enable bit cleared
    @(negedge clk); cmd_enables = 2'b11; rom_reg = 32'h8000_0000;
    access(1'b0, 32'h8001_8000);
    chk("R2 rom off", 32'(hit), 32'h0);
    // R2 ROM enable set, memory enable cleared
    @(negedge clk); rom_reg = 32'h8000_0001; cmd_enables = 2'b01;
    access(1'b0, 32'h8001_8000);
    chk("R2 rom mem off", 32'(hit), 32'h0);

    // R10 latency: immediate decode, registered map one edge later
    @(negedge clk); cmd_enables = 2'b11;
    @(posedge clk); #1;
    chk("R10 settled", 32'(map_valid), 32'h47);
    @(negedge clk); cmd_enables = 2'b00;
    #1;
    chk("R10 before edge", 32'(map_valid), 32'h47);
    @(posedge clk); #1;
    chk("R10 after edge", 32'(map_valid), 32'h0);
    chk("R10 unmapped base", map_base[1*32 +: 32], 32'h0);

    // R5 R3 top-of-space memory region, no wrap
    @(negedge clk); cmd_enables = 2'b11;
    bar_vals[5*32 +: 32] = 32'hFFFF_F000;
    access(1'b0, 32'hFFFF_FFFF);
    chk("R5 top hit", 32'(hit), 32'h1);
    chk("R5 top idx", 32'(hit_idx), 32'h5);
    chk("R8 top off", hit_off, 32'h0000_0FFF);

    // R6 zero-size BAR3 stays unmapped even when placed
    @(posedge clk); #1;
    chk("R6 BAR3 valid", 32'(map_valid[3]), 32'h0);

    summary();
  end
endmodule